// File: doc/BRIEF.md
# Back-projection partial pixel engine

This block walks every pixel of an N×N image once per view angle and, for each pixel, works out which detector bin of a filtered projection the pixel falls on. The pixel is treated as a signed offset from the image centre. Its detector coordinate t = x·cos θ + y·sin θ is formed with fixed-point sine and cosine values, floored to an integer bin, and shifted by the projection centre to give a buffer address. The block reads the filtered projection sample at that address from an external buffer and emits it as one partial pixel per clock. Summing the partial pixels across angles into an image is done elsewhere.

Pixels are swept in raster order, from the top row down and left to right within a row. All N² pixels of one angle are emitted before the next angle starts. After reset, the sweep first runs through two dummy angle periods. These give the upstream ping-pong filter time to fill its first bank. After that the stream runs without gaps, frame after frame. Strobes mark the last pixel of each angle and the last pixel of each frame.

Top module: `bp_backproj_engine`

## Requirements
- R1: While rst_n is low, and until the first valid partial pixel, pix_valid, pix_eoa, pix_eof and rd_en are low and pix_data is zero.
- R2: The first valid partial pixel is on the outputs after the (2·N²+6)-th rising clock edge following the release of rst_n. This covers two synchroniser cycles, two dummy angle periods of N² cycles each, and a four-cycle pipeline.
- R3: Within one angle, pixels are emitted row by row. y runs from c−1 down to c−N, and within a row x runs from 1−c up to N−c, where c = floor((N+1)/2).
- R4: The angle index a runs from 0 to A−1 with θ = a·ANG_STEP degrees and A = 180/ANG_STEP. All N² pixels of angle a come before angle a+1, and index 0 follows A−1 without a gap.
- R5: The cosine and sine of θ are 12-bit signed values with 10 fractional bits, rounded to the nearest value with halves rounded away from zero.
- R6: For each valid pixel, the buffer address is floor((x·C + y·S)/1024) + ceil(L/2), where C and S are the coded cosine and sine. rd_en is high exactly when that address lies in 0..L−1, and rd_addr then carries it. The buffer returns rd_data on the next cycle.
- R7: For an in-range pixel, pix_data equals the rd_data returned for that pixel's address. It appears two cycles after the pixel's rd_addr.
- R8: When the address falls outside 0..L−1, pix_data is zero, whatever value rd_data has.
- R9: pix_eoa is high, together with pix_valid, exactly on the last pixel (bottom-right) of every angle.
- R10: pix_eof is high exactly on the last pixel of angle A−1, and pix_eoa is also high in that cycle.
- R11: Once pix_valid has risen, it stays high on every cycle, so frames of A·N² partial pixels follow one another back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally in step with clk |
| rd_addr | output | ceil(log2(L)) | Filtered projection buffer read address |
| rd_en | output | 1 | Read strobe, high when the address is in range |
| rd_data | input | DATA_W | Buffer sample, one cycle after rd_addr |
| pix_data | output | DATA_W | Partial pixel value |
| pix_valid | output | 1 | Partial pixel valid |
| pix_eoa | output | 1 | Last pixel of the current angle |
| pix_eof | output | 1 | Last pixel of the last angle |

## Verification
The default projection length is short enough that corner pixels at diagonal angles fall off both ends of the buffer. A design that clamped the address instead of zeroing the pixel, or that passed through the stale read data, would show non-zero pixels there. The bench's buffer returns a fixed garbage pattern when rd_en is low, which exposes any mask that is missing. Negative coordinates check that the bin index is floored rather than truncated toward zero: truncation would move the address by one on half of the image. The bench follows the stream across the wrap from the last angle back to angle 0. It checks the exact cycle of the first valid pixel, so an error in the warm-up length or the pipeline depth shows up as a shifted stream.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef struct packed {
    logic valid;
    logic eoa;
    logic eof;
  } bp_meta_t;

  // Fixed-point sine/cosine code, rounded half away from zero.
  function automatic int trig_code(int deg, bit want_sin, int frac);
    real rad;
    real v;
    real s;
    rad = real'(deg) * 3.14159265358979323846 / 180.0;
    v   = want_sin ? $sin(rad) : $cos(rad);
    s   = v * (2.0 ** frac);
    if (s >= 0.0) return $rtoi(s + 0.5);
    else          return -$rtoi(0.5 - s);
  endfunction

endpackage

// File: rtl/bp_sweep_ctr.sv
module bp_sweep_ctr
  import bp_pkg::*;
#(
  parameter int IMG_N       = 16,
  parameter int NUM_ANG     = 45,
  parameter int LEAD_ANGLES = 2,
  localparam int PIX_W = $clog2(IMG_N + 1),
  localparam int ANG_W = $clog2(NUM_ANG + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [PIX_W-1:0] col,
  output logic [PIX_W-1:0] row,
  output logic [ANG_W-1:0] ang,
  output bp_meta_t         meta
);

  localparam int LEAD_W = $clog2(LEAD_ANGLES + 2);

  logic [PIX_W-1:0]  col_q, col_d, row_q, row_d;
  logic [ANG_W-1:0]  ang_q, ang_d;
  logic [LEAD_W-1:0] lead_q, lead_d;
  logic col_last, row_last, pix_last, ang_last, lead_done;
  logic row_en, ang_en, lead_en;

  always_comb begin
    col_last  = (col_q == PIX_W'(IMG_N - 1));
    row_last  = (row_q == PIX_W'(IMG_N - 1));
    ang_last  = (ang_q == ANG_W'(NUM_ANG - 1));
    pix_last  = col_last & row_last;
    lead_done = (lead_q == LEAD_W'(LEAD_ANGLES));
    row_en    = col_last;
    lead_en   = pix_last & ~lead_done;
    ang_en    = pix_last & lead_done;
    col_d     = col_last ? '0 : col_q + 1'b1;
    row_d     = row_last ? '0 : row_q + 1'b1;
    lead_d    = lead_q + 1'b1;
    ang_d     = ang_last ? '0 : ang_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      row_q  <= '0;
      ang_q  <= '0;
      lead_q <= '0;
    end else begin
      col_q <= col_d;
      if (row_en)  row_q  <= row_d;
      if (lead_en) lead_q <= lead_d;
      if (ang_en)  ang_q  <= ang_d;
    end
  end

  assign col       = col_q;
  assign row       = row_q;
  assign ang       = ang_q;
  assign meta.valid = lead_done;
  assign meta.eoa   = lead_done & pix_last;
  assign meta.eof   = lead_done & pix_last & ang_last;

  AST_ANG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ang_q < ANG_W'(NUM_ANG)); // R4

  AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (col_q == PIX_W'(IMG_N - 1)) |=> (col_q == '0)); // R3

endmodule

// File: rtl/bp_trig_lut.sv
module bp_trig_lut
  import bp_pkg::*;
#(
  parameter int NUM_ANG   = 45,
  parameter int ANG_STEP  = 4,
  parameter int TRIG_W    = 12,
  parameter int TRIG_FRAC = 10,
  localparam int ANG_W = $clog2(NUM_ANG + 1)
) (
  input  logic [ANG_W-1:0]         ang,
  output logic signed [TRIG_W-1:0] cos_v,
  output logic signed [TRIG_W-1:0] sin_v
);

  logic signed [TRIG_W-1:0] cos_tab [NUM_ANG];
  logic signed [TRIG_W-1:0] sin_tab [NUM_ANG];

  for (genvar g = 0; g < NUM_ANG; g++) begin : g_ang
    localparam int COS_I = trig_code(g * ANG_STEP, 1'b0, TRIG_FRAC);
    localparam int SIN_I = trig_code(g * ANG_STEP, 1'b1, TRIG_FRAC);
    assign cos_tab[g] = TRIG_W'(COS_I);
    assign sin_tab[g] = TRIG_W'(SIN_I);
  end

  assign cos_v = cos_tab[ang];
  assign sin_v = sin_tab[ang];

endmodule

// File: rtl/bp_coord_addr.sv
module bp_coord_addr
  import bp_pkg::*;
#(
  parameter int IMG_N     = 16,
  parameter int PROJ_LEN  = 21,
  parameter int TRIG_W    = 12,
  parameter int TRIG_FRAC = 10,
  localparam int PIX_W  = $clog2(IMG_N + 1),
  localparam int ADDR_W = $clog2(PROJ_LEN)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PIX_W-1:0]         col,
  input  logic [PIX_W-1:0]         row,
  input  logic signed [TRIG_W-1:0] cos_v,
  input  logic signed [TRIG_W-1:0] sin_v,
  input  bp_meta_t                 meta_in,
  output logic [ADDR_W-1:0]        rd_addr,
  output logic                     rd_en,
  output logic                     inr_out,
  output bp_meta_t                 meta_out
);

  localparam int CW     = PIX_W + 1;
  localparam int SW     = CW + TRIG_W + 1;
  localparam int C_CTR  = (IMG_N + 1) / 2;
  localparam int P_CTR  = (PROJ_LEN + 1) / 2;

  logic signed [CW-1:0] x_s, y_s;
  logic signed [SW-1:0] sum_d, sum_q, addr_full;
  logic                 inr_d, inr_q;
  logic [ADDR_W-1:0]    addr_q;
  bp_meta_t             meta1_q, meta2_q;

  always_comb begin
    x_s       = CW'(col) - CW'(C_CTR - 1);
    y_s       = CW'(C_CTR - 1) - CW'(row);
    sum_d     = SW'(x_s) * SW'(cos_v) + SW'(y_s) * SW'(sin_v);
    addr_full = (sum_q >>> TRIG_FRAC) + SW'(P_CTR);
    inr_d     = ~addr_full[SW-1] & (addr_full < SW'(PROJ_LEN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q   <= '0;
      meta1_q <= '0;
      addr_q  <= '0;
      inr_q   <= 1'b0;
      meta2_q <= '0;
    end else begin
      sum_q   <= sum_d;
      meta1_q <= meta_in;
      addr_q  <= addr_full[ADDR_W-1:0];
      inr_q   <= inr_d;
      meta2_q <= meta1_q;
    end
  end

  assign rd_addr  = addr_q;
  assign rd_en    = meta2_q.valid & inr_q;
  assign inr_out  = inr_q;
  assign meta_out = meta2_q;

  AST_RD_IN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_addr < ADDR_W'(PROJ_LEN))); // R6

  AST_RD_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> meta_out.valid); // R6

endmodule

// File: rtl/bp_out_stage.sv
module bp_out_stage
  import bp_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bp_meta_t          meta_in,
  input  logic              inr_in,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] pix_data,
  output logic              pix_valid,
  output logic              pix_eoa,
  output logic              pix_eof
);

  bp_meta_t          meta3_q;
  logic              inr3_q;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    data_d = (meta3_q.valid & inr3_q) ? rd_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta3_q   <= '0;
      inr3_q    <= 1'b0;
      pix_data  <= '0;
      pix_valid <= 1'b0;
      pix_eoa   <= 1'b0;
      pix_eof   <= 1'b0;
    end else begin
      meta3_q   <= meta_in;
      inr3_q    <= inr_in;
      pix_data  <= data_d;
      pix_valid <= meta3_q.valid;
      pix_eoa   <= meta3_q.eoa;
      pix_eof   <= meta3_q.eof;
    end
  end

  AST_VALID_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> pix_valid); // R11

  AST_EOA_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    pix_eoa |-> pix_valid); // R9

  AST_EOF_WITH_EOA: assert property (@(posedge clk) disable iff (!rst_n)
    pix_eof |-> pix_eoa); // R10

endmodule

// File: rtl/bp_backproj_engine.sv
module bp_backproj_engine
  import bp_pkg::*;
#(
  parameter int IMG_N       = 16,
  parameter int ANG_STEP    = 4,
  parameter int PROJ_LEN    = 21,
  parameter int TRIG_W      = 12,
  parameter int TRIG_FRAC   = 10,
  parameter int DATA_W      = 18,
  parameter int LEAD_ANGLES = 2,
  localparam int NUM_ANG = 180 / ANG_STEP,
  localparam int PIX_W   = $clog2(IMG_N + 1),
  localparam int ANG_W   = $clog2(NUM_ANG + 1),
  localparam int ADDR_W  = $clog2(PROJ_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_en,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] pix_data,
  output logic              pix_valid,
  output logic              pix_eoa,
  output logic              pix_eof
);

  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic [PIX_W-1:0]         col, row;
  logic [ANG_W-1:0]         ang;
  logic signed [TRIG_W-1:0] cos_v, sin_v;
  bp_meta_t                 meta0, meta2;
  logic                     inr2;

  bp_sweep_ctr #(.IMG_N(IMG_N), .NUM_ANG(NUM_ANG), .LEAD_ANGLES(LEAD_ANGLES)) u_ctr (
    .clk(clk), .rst_n(rst_i_n), .col(col), .row(row), .ang(ang), .meta(meta0)
  );

  bp_trig_lut #(.NUM_ANG(NUM_ANG), .ANG_STEP(ANG_STEP), .TRIG_W(TRIG_W),
                .TRIG_FRAC(TRIG_FRAC)) u_trig (
    .ang(ang), .cos_v(cos_v), .sin_v(sin_v)
  );

  bp_coord_addr #(.IMG_N(IMG_N), .PROJ_LEN(PROJ_LEN), .TRIG_W(TRIG_W),
                  .TRIG_FRAC(TRIG_FRAC)) u_coord (
    .clk(clk), .rst_n(rst_i_n), .col(col), .row(row), .cos_v(cos_v), .sin_v(sin_v),
    .meta_in(meta0), .rd_addr(rd_addr), .rd_en(rd_en), .inr_out(inr2), .meta_out(meta2)
  );

  bp_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_i_n), .meta_in(meta2), .inr_in(inr2), .rd_data(rd_data),
    .pix_data(pix_data), .pix_valid(pix_valid), .pix_eoa(pix_eoa), .pix_eof(pix_eof)
  );

endmodule

// File: tb/bp_backproj_engine_bench.sv
`timescale 1ns/1ps
module bp_backproj_engine_bench;

  localparam int N      = 16;
  localparam int STEP   = 4;
  localparam int L      = 21;
  localparam int DW     = 18;
  localparam int NA     = 180 / STEP;
  localparam int AW     = $clog2(L);
  localparam int CTR    = (N + 1) / 2;
  localparam int PCTR   = (L + 1) / 2;
  localparam int NPIX   = N * N;
  localparam int FIRST  = 2 * NPIX + 6;
  localparam int EXTRA  = 600;
  localparam int LAST_E = FIRST + NA * NPIX + EXTRA - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] rd_addr;
  logic          rd_en;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] pix_data;
  logic          pix_valid, pix_eoa, pix_eof;

  always #10 clk = ~clk;

  bp_backproj_engine #(.IMG_N(N), .ANG_STEP(STEP), .PROJ_LEN(L), .DATA_W(DW)) u_bp_backproj_engine (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(rd_data),
    .pix_data(pix_data), .pix_valid(pix_valid), .pix_eoa(pix_eoa), .pix_eof(pix_eof)
  );

  function automatic logic [DW-1:0] mem_val(int a);
    return DW'(a * 1237 + 4321 + (a % 3) * 131072);
  endfunction

  // Synchronous-read buffer model; garbage when not enabled.
  always @(posedge clk) rd_data <= rd_en ? mem_val(int'(rd_addr)) : 18'h2AAAA;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int trig_ref(int deg, bit want_sin);
    real rad, s;
    rad = real'(deg) * 3.14159265358979323846 / 180.0;
    s = (want_sin ? $sin(rad) : $cos(rad)) * 1024.0;
    if (s >= 0.0) return $rtoi(s + 0.5);
    return -$rtoi(0.5 - s);
  endfunction

  // Reference for counter index k (k >= 2*NPIX): address, strobes.
  task automatic ref_pix(input int k, output int addr, output bit eoa, output bit eof);
    int j, a, p, r, c, x, y, t;
    j = k - 2 * NPIX;
    a = (j / NPIX) % NA;
    p = j % NPIX;
    r = p / N;
    c = p % N;
    x = c + 1 - CTR;
    y = CTR - 1 - r;
    t = x * trig_ref(a * STEP, 1'b0) + y * trig_ref(a * STEP, 1'b1);
    addr = (t >>> 10) + PCTR;
    eoa = (p == NPIX - 1);
    eof = eoa && (a == NA - 1);
  endtask

  int n_lo = 0, n_hi = 0, n_eoa = 0, n_eof = 0, n_valid = 0;

  initial begin
    int addr, ka, ko;
    bit eoa, eof, inr, expv;
    logic [DW-1:0] expd;
    repeat (3) @(negedge clk);
    chk(pix_valid == 0 && rd_en == 0 && pix_eoa == 0 && pix_eof == 0, "R1 reset strobes",
        {pix_valid, rd_en, pix_eoa, pix_eof}, 0);
    chk(pix_data == 0, "R1 reset data", pix_data, 0);
    rst_n = 1'b1;
    for (int e = 1; e <= LAST_E; e++) begin
      @(posedge clk);
      @(negedge clk);
      // address stage: counter index e-4
      ka = e - 4;
      if (ka >= 2 * NPIX) begin
        ref_pix(ka, addr, eoa, eof);
        inr = (addr >= 0 && addr < L);
        chk(rd_en == inr, "R6 rd_en", rd_en, inr);
        if (inr) chk(int'(rd_addr) == addr, "R6 rd_addr", rd_addr, addr);
      end else begin
        chk(rd_en == 0, "R1 rd_en idle", rd_en, 0);
      end
      // output stage: counter index e-6
      ko = e - 6;
      expv = (ko >= 2 * NPIX);
      chk(pix_valid == expv, expv ? "R2 R11 pix_valid" : "R1 pix_valid low", pix_valid, expv);
      if (expv) begin
        ref_pix(ko, addr, eoa, eof);
        inr = (addr >= 0 && addr < L);
        expd = inr ? mem_val(addr) : '0;
        if (!inr && addr < 0) n_lo++;
        if (!inr && addr >= L) n_hi++;
        chk(pix_data == expd, inr ? "R7 R3 R4 R5 pix_data" : "R8 out-of-range zero",
            pix_data, expd);
        chk(pix_eoa == eoa, "R9 pix_eoa", pix_eoa, eoa);
        chk(pix_eof == eof, "R10 pix_eof", pix_eof, eof);
        n_valid++;
        if (pix_eoa) n_eoa++;
        if (pix_eof) n_eof++;
      end else begin
        chk(pix_eoa == 0 && pix_eof == 0, "R1 strobes idle", {pix_eoa, pix_eof}, 0);
      end
      if (e == FIRST) chk(pix_valid == 1, "R2 first valid edge", pix_valid, 1);
      if (e == FIRST - 1) chk(pix_valid == 0, "R2 no early valid", pix_valid, 0);
    end
    chk(n_lo > 0 && n_hi > 0, "R8 both sides out of range seen", n_lo * 1000 + n_hi, 1);
    chk(n_eoa == n_valid / NPIX, "R9 eoa count", n_eoa, n_valid / NPIX);
    chk(n_eof == 1, "R10 eof count", n_eof, 1);
    chk(n_valid == NA * NPIX + EXTRA, "R4 R11 frame wrap stream length", n_valid, NA * NPIX + EXTRA);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule